// File: doc/BRIEF.md
# Load/Store Byte-Lane Steering Unit

This unit sits between a processor's load/store pipeline and a data bus with one enable per byte lane. For a store it takes the source register, the low address bits and the access size. It then produces the lane enables and moves the register bytes onto the lanes those enables select. For a load it takes the word returned by the bus and picks out the addressed lanes. It right-justifies them into a register-wide result, with sign or zero extension as requested.

The bus width is a parameter of 32 or 64 bits, and the register width equals the bus width. A 64-bit build also accepts doubleword accesses. The lane mapping is fixed and little-endian: lane *n* carries address offset *n*. Narrow devices wired to the top lanes are therefore reached by addressing the top offsets, and no width conversion is involved. An access that is not naturally aligned, or that is wider than the bus, raises a misalign error. Such an access never reaches the bus. The unit never splits an access into several beats.

Size encoding used on both paths: 0 = byte (1 lane), 1 = halfword (2 lanes), 2 = word (4 lanes), 3 = doubleword (8 lanes).

Top module: `lane_steer`

## Requirements
- R1: A legal byte request at offset `o` drives exactly one enable, bit `o` of `bus_be` (on a 32-bit bus: offset 3 gives 1000, offset 0 gives 0001).
- R2: A legal halfword, word or doubleword request at offset `o` enables the contiguous lanes `o` up to `o+N-1`, where N is 2, 4 or 8 (for example, halfword at 2 gives 1100, word at 4 gives 11110000, doubleword at 0 gives all ones).
- R3: On a legal store, register byte `k` (bits 8k+7:8k) appears on bus lane `o+k`. A halfword at offset 2 therefore puts bits 15:8 on lane 3 and bits 7:0 on lane 2.
- R4: Every write-data lane that is not enabled is zero. On a load request (`req_write`=0) the whole write bus is zero and `bus_we` is low.
- R5: A request whose offset is not a multiple of its size, or a doubleword on a 32-bit bus, raises `misalign_err`. In that case `bus_be` is zero and `bus_req` is low.
- R6: A legal load places bus lane `o+k` into result byte `k`. A byte fills bits 7:0, a halfword bits 15:0, a word bits 31:0 and a doubleword the full 64 bits.
- R7: With `rd_signed`=1, the result bits above the extracted data copy the top bit of the most significant extracted byte. With `rd_signed`=0 they are zero.
- R8: `rd_done` is high exactly in the cycle after a cycle with `rd_valid` high, and the result is registered on that edge. Without `rd_valid`, `rd_result` holds its value.
- R9: A misaligned load (same rule as R5) returns `rd_err`=1 with `rd_result` all zero.
- R10: A byte device on the top lane is served by offset NB-1: a store there uses only the top lane, and a load there returns that lane in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request presented this cycle |
| req_write | input | 1 | 1 = store, 0 = load request |
| req_size | input | 2 | Access size code |
| req_off | input | log2(BUS_W/8) | Low address bits |
| req_wdata | input | BUS_W | Source register value for stores |
| bus_req | output | 1 | Legal request issued to the bus |
| bus_we | output | 1 | Bus write strobe |
| bus_be | output | BUS_W/8 | Byte-lane enables |
| bus_wdata | output | BUS_W | Steered write data |
| misalign_err | output | 1 | Request rejected as misaligned |
| rd_valid | input | 1 | Read data returned this cycle |
| rd_size | input | 2 | Size code of the returning load |
| rd_off | input | log2(BUS_W/8) | Low address bits of the returning load |
| rd_signed | input | 1 | Sign-extend the extracted data |
| rd_bus | input | BUS_W | Read data from the bus |
| rd_done | output | 1 | Registered result valid |
| rd_err | output | 1 | Registered misalign flag for the load |
| rd_result | output | BUS_W | Right-justified, extended load result |

## Verification
The bench builds two instances side by side, one with BUS_W=64 and one with BUS_W=32, and drives them with the same stimulus. The 64-bit build exercises offsets 0 to 7 and the doubleword size. The 32-bit build checks that a doubleword is rejected there and that its word and halfword placement works over only four lanes. A byte-addressed memory model in the bench supplies read data across every size, offset, signedness and sign-bit pattern. This includes every misaligned combination and the top-lane device case.

// File: rtl/lsu_steer_pkg.sv
// Shared size codes and helpers for the byte-lane steering unit.
// Assumes size codes 0..3 map to 1, 2, 4, 8 bytes.
package lsu_steer_pkg;
    localparam logic [1:0] SZ_BYTE  = 2'd0;
    localparam logic [1:0] SZ_HALF  = 2'd1;
    localparam logic [1:0] SZ_WORD  = 2'd2;
    localparam logic [1:0] SZ_DWORD = 2'd3;

    // Number of bytes moved by an access of the given size code.
    function automatic int xfer_bytes(input logic [1:0] size);
        return 1 << size;
    endfunction
endpackage

// File: rtl/lsu_align_chk.sv
// Natural-alignment check: flags an offset that is not a multiple of the
// access size, or an access wider than the NB-lane bus. Purely combinational.
module lsu_align_chk
    import lsu_steer_pkg::*;
#(
    parameter  int NB    = 8,
    localparam int OFS_W = $clog2(NB)
) (
    input  logic [1:0]       size_i,
    input  logic [OFS_W-1:0] off_i,
    output logic             mis_o
);
    int               nbytes;
    logic [OFS_W-1:0] low_mask;

    // Compare the low offset bits against the size and the size against the bus.
    always_comb begin
        nbytes   = xfer_bytes(size_i);
        low_mask = OFS_W'(nbytes - 1);
        mis_o    = (nbytes > NB) || ((off_i & low_mask) != '0);
    end
endmodule

// File: rtl/lsu_store_steer.sv
// Store-side steering: builds lane enables from offset and size and moves
// register byte k onto lane off+k. Assumes the request is already aligned
// whenever en_i is high; with en_i low all enables and data are zero.
module lsu_store_steer
    import lsu_steer_pkg::*;
#(
    parameter  int BUS_W = 64,
    localparam int NB    = BUS_W / 8,
    localparam int OFS_W = $clog2(NB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             wr_i,
    input  logic [1:0]       size_i,
    input  logic [OFS_W-1:0] off_i,
    input  logic [BUS_W-1:0] data_i,
    output logic [NB-1:0]    be_o,
    output logic [BUS_W-1:0] wdata_o
);
    int nbytes;

    // Width of the access in lanes.
    always_comb nbytes = xfer_bytes(size_i);

    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic             hit;
        logic [OFS_W-1:0] src;

        // Decide whether this lane is covered and which register byte feeds it.
        always_comb begin
            hit = en_i && (i >= int'(off_i)) && (i < int'(off_i) + nbytes);
            src = OFS_W'(i) - off_i;
        end

        assign be_o[i]           = hit;
        assign wdata_o[8*i +: 8] = (hit && wr_i) ? data_i[{src, 3'b000} +: 8] : 8'h00;
    end

    // R1: a byte access drives exactly one lane enable
    p_byte_one_lane_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && size_i == SZ_BYTE) |-> ($countones(be_o) == 1));

    // R1: the lane enabled for a byte is the one named by the offset
    p_byte_lane_pos_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && size_i == SZ_BYTE) |-> be_o[off_i]);
endmodule

// File: rtl/lsu_load_steer.sv
// Load-side steering: extracts the addressed lanes of the returned bus word,
// right-justifies them and extends to the full register width. The result is
// registered on each rd_valid cycle and held otherwise. Assumes the size and
// offset presented with rd_valid belong to the returning data.
module lsu_load_steer
    import lsu_steer_pkg::*;
#(
    parameter  int BUS_W = 64,
    localparam int NB    = BUS_W / 8,
    localparam int OFS_W = $clog2(NB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [1:0]       size_i,
    input  logic [OFS_W-1:0] off_i,
    input  logic             signed_i,
    input  logic             mis_i,
    input  logic [BUS_W-1:0] bus_i,
    output logic             done_o,
    output logic             err_o,
    output logic [BUS_W-1:0] result_o
);
    int               nbytes;
    logic [OFS_W-1:0] top_src;
    logic             fill;
    logic [BUS_W-1:0] nxt;

    // Find the most significant extracted lane and derive the extension bit.
    always_comb begin
        nbytes  = xfer_bytes(size_i);
        top_src = off_i + OFS_W'(nbytes - 1);
        fill    = signed_i && bus_i[{top_src, 3'b111}];
    end

    for (genvar j = 0; j < NB; j++) begin : g_res
        logic [OFS_W-1:0] src;
        assign src = OFS_W'(j) + off_i;
        assign nxt[8*j +: 8] = mis_i        ? 8'h00 :
                               (j < nbytes) ? bus_i[{src, 3'b000} +: 8] :
                                              {8{fill}};
    end

    // Register the steered result one cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o   <= 1'b0;
            err_o    <= 1'b0;
            result_o <= '0;
        end else begin
            done_o <= valid_i;
            err_o  <= valid_i && mis_i;
            if (valid_i) result_o <= nxt;
        end
    end

    // R8: a read strobe is answered in the following cycle
    p_done_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> done_o);

    // R8: with no strobe the result is held and no completion is signalled
    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!done_o && $stable(result_o)));

    // R9: a rejected load returns an all-zero result
    p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (done_o && result_o == '0));
endmodule

// File: rtl/lane_steer.sv
// Top of the byte-lane steering unit. Alignment is checked separately for the
// request path and the read-return path. Legal requests are steered onto the
// bus; illegal ones are flagged and kept off it. Assumes BUS_W is 32 or 64 and
// that the register width equals the bus width.
module lane_steer
    import lsu_steer_pkg::*;
#(
    parameter  int BUS_W = 64,
    localparam int NB    = BUS_W / 8,
    localparam int OFS_W = $clog2(NB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_size,
    input  logic [OFS_W-1:0] req_off,
    input  logic [BUS_W-1:0] req_wdata,
    output logic             bus_req,
    output logic             bus_we,
    output logic [NB-1:0]    bus_be,
    output logic [BUS_W-1:0] bus_wdata,
    output logic             misalign_err,
    input  logic             rd_valid,
    input  logic [1:0]       rd_size,
    input  logic [OFS_W-1:0] rd_off,
    input  logic             rd_signed,
    input  logic [BUS_W-1:0] rd_bus,
    output logic             rd_done,
    output logic             rd_err,
    output logic [BUS_W-1:0] rd_result
);
    logic             req_mis;
    logic             rd_mis;
    logic [BUS_W-1:0] be_bits;

    lsu_align_chk #(.NB(NB)) i_req_chk (
        .size_i (req_size),
        .off_i  (req_off),
        .mis_o  (req_mis)
    );

    lsu_align_chk #(.NB(NB)) i_rd_chk (
        .size_i (rd_size),
        .off_i  (rd_off),
        .mis_o  (rd_mis)
    );

    // Only aligned requests reach the bus; rejected ones raise the error.
    always_comb begin
        bus_req      = req_valid && !req_mis;
        bus_we       = bus_req && req_write;
        misalign_err = req_valid && req_mis;
    end

    lsu_store_steer #(.BUS_W(BUS_W)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (bus_req),
        .wr_i    (req_write),
        .size_i  (req_size),
        .off_i   (req_off),
        .data_i  (req_wdata),
        .be_o    (bus_be),
        .wdata_o (bus_wdata)
    );

    lsu_load_steer #(.BUS_W(BUS_W)) i_load (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (rd_valid),
        .size_i   (rd_size),
        .off_i    (rd_off),
        .signed_i (rd_signed),
        .mis_i    (rd_mis),
        .bus_i    (rd_bus),
        .done_o   (rd_done),
        .err_o    (rd_err),
        .result_o (rd_result)
    );

    // Expand the lane enables to a bit mask for the data-lane checks.
    for (genvar k = 0; k < NB; k++) begin : g_mask
        assign be_bits[8*k +: 8] = {8{bus_be[k]}};
    end

    // R5: a rejected request drives no enables and no bus request
    p_misalign_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_err |-> (bus_be == '0 && !bus_req && !bus_we));

    // R2: an issued request enables as many lanes as its size
    p_lane_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> ($countones(bus_be) == xfer_bytes(req_size)));

    // R4: lanes outside the enables carry zero on a store
    p_idle_lanes_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> ((bus_wdata & ~be_bits) == '0));

    // R4: a load request leaves the write bus at zero
    p_load_no_wdata_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !req_write) |-> (bus_wdata == '0 && !bus_we));

    if (BUS_W == 32) begin : g_narrow
        // R5: a doubleword can never be issued on a 32-bit bus
        p_no_dword_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_size == SZ_DWORD) |-> misalign_err);
    end
endmodule

// File: tb/test_lane_steer.sv
// Self-checking bench: a 64-bit and a 32-bit instance share one stimulus.
// Expected lane enables and data come from a byte-addressed memory model.
module test_lane_steer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic [2:0]  req_off = '0;
    logic [63:0] req_wdata = '0;
    logic        rd_valid = 1'b0, rd_signed = 1'b0;
    logic [1:0]  rd_size = '0;
    logic [2:0]  rd_off = '0;
    logic [63:0] rd_bus = '0;

    logic        b64_req, b64_we, b64_mis, r64_done, r64_err;
    logic [7:0]  b64_be;
    logic [63:0] b64_wd, r64_res;
    logic        b32_req, b32_we, b32_mis, r32_done, r32_err;
    logic [3:0]  b32_be;
    logic [31:0] b32_wd, r32_res;

    int checks = 0, failures = 0, cycles = 0;
    logic [7:0] mem [8];

    always #2.5 clk = ~clk;

    lane_steer #(.BUS_W(64)) i_lane_steer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_off(req_off), .req_wdata(req_wdata),
        .bus_req(b64_req), .bus_we(b64_we), .bus_be(b64_be), .bus_wdata(b64_wd),
        .misalign_err(b64_mis), .rd_valid(rd_valid), .rd_size(rd_size),
        .rd_off(rd_off), .rd_signed(rd_signed), .rd_bus(rd_bus),
        .rd_done(r64_done), .rd_err(r64_err), .rd_result(r64_res));

    lane_steer #(.BUS_W(32)) i_lane_steer_w32 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_off(req_off[1:0]), .req_wdata(req_wdata[31:0]),
        .bus_req(b32_req), .bus_we(b32_we), .bus_be(b32_be), .bus_wdata(b32_wd),
        .misalign_err(b32_mis), .rd_valid(rd_valid), .rd_size(rd_size),
        .rd_off(rd_off[1:0]), .rd_signed(rd_signed), .rd_bus(rd_bus[31:0]),
        .rd_done(r32_done), .rd_err(r32_err), .rd_result(r32_res));

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Drive one request and compare enables, data and error against the model.
    task automatic do_req(input bit w32, input bit wr, input int size, input int off,
                          input logic [63:0] data);
        int nb = w32 ? 4 : 8;
        int nbytes = 1 << size;
        bit legal = ((off % nbytes) == 0) && (nbytes <= nb);
        logic [7:0]  ebe = '0;
        logic [63:0] ewd = '0;
        logic [63:0] d = w32 ? {32'h0, data[31:0]} : data;
        logic [7:0]  abe;
        logic [63:0] awd;
        logic        areq, amis, awe;
        string       tag;
        if (legal) begin
            for (int k = 0; k < nbytes; k++) begin
                ebe[off + k] = 1'b1;
                if (wr) ewd[8*(off + k) +: 8] = d[8*k +: 8];
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = 2'(size);
        req_off = 3'(off); req_wdata = data;
        #1;
        abe  = w32 ? {4'h0, b32_be} : b64_be;
        awd  = w32 ? {32'h0, b32_wd} : b64_wd;
        areq = w32 ? b32_req : b64_req;
        awe  = w32 ? b32_we : b64_we;
        amis = w32 ? b32_mis : b64_mis;
        if (!legal) tag = "R5";
        else if (size == 0 && off == nb - 1) tag = "R10";
        else if (size == 0) tag = "R1";
        else tag = "R2";
        check(abe == ebe && areq == legal && amis == !legal, tag,
              {54'h0, areq, amis, abe}, {54'h0, legal, !legal, ebe});
        tag = !legal ? "R5" : (wr ? "R3" : "R4");
        check(awd == ewd && awe == (legal && wr), tag, awd, ewd);
        req_valid = 1'b0;
    endtask

    // Return a load from the memory model and check the registered result.
    task automatic do_load(input bit w32, input int size, input int off,
                           input bit sgn, input bit neg);
        int nb = w32 ? 4 : 8;
        int nbytes = 1 << size;
        bit legal = ((off % nbytes) == 0) && (nbytes <= nb);
        logic [63:0] word = '0, exp = '0, hold, act;
        string tag;
        bit adone, aerr;
        for (int b = 0; b < 8; b++) mem[b] = 8'($urandom);
        if (legal) mem[off + nbytes - 1] = neg ? (mem[off + nbytes - 1] | 8'h80)
                                               : (mem[off + nbytes - 1] & 8'h7f);
        for (int b = 0; b < nb; b++) word[8*b +: 8] = mem[b];
        if (legal) begin
            for (int k = 0; k < nbytes; k++) exp[8*k +: 8] = mem[off + k];
            if (sgn && neg)
                for (int bit_i = 8 * nbytes; bit_i < 8 * nb; bit_i++) exp[bit_i] = 1'b1;
        end
        @(negedge clk);
        rd_valid = 1'b1; rd_size = 2'(size); rd_off = 3'(off);
        rd_signed = sgn; rd_bus = word;
        @(negedge clk);
        rd_valid = 1'b0;
        rd_bus = ~word;
        #1;
        act   = w32 ? {32'h0, r32_res} : r64_res;
        adone = w32 ? r32_done : r64_done;
        aerr  = w32 ? r32_err : r64_err;
        if (!legal) tag = "R9";
        else if (size == 0 && off == nb - 1) tag = "R10";
        else if (sgn && size < 3 && !(w32 && size == 2)) tag = "R7";
        else tag = "R6";
        check(act == exp && adone && aerr == !legal, tag, act, exp);
        hold = act;
        @(negedge clk);
        #1;
        act   = w32 ? {32'h0, r32_res} : r64_res;
        adone = w32 ? r32_done : r64_done;
        check(act == hold && !adone, "R8", act, hold);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(r64_res == '0 && !r64_done && !r64_err && r32_res == '0 && !r32_done,
              "R8 reset", r64_res, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!b64_req && !b64_mis && b64_be == '0 && b64_wd == '0, "R5 idle",
              {56'h0, b64_be}, 64'h0);

        for (int w = 0; w < 2; w++)
            for (int s = 0; s < 4; s++)
                for (int o = 0; o < (w ? 4 : 8); o++) begin
                    do_req(w[0], 1'b1, s, o, {$urandom, $urandom});
                    do_req(w[0], 1'b0, s, o, {$urandom, $urandom});
                end

        for (int w = 0; w < 2; w++)
            for (int s = 0; s < 4; s++)
                for (int o = 0; o < (w ? 4 : 8); o++)
                    for (int sg = 0; sg < 2; sg++)
                        for (int ng = 0; ng < 2; ng++)
                            do_load(w[0], s, o, sg[0], ng[0]);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule